// File: doc/BRIEF.md
# Drift-Compensated Precision Time Counter

This block keeps a 64-bit nanosecond time value for precision time protocol work. It runs in a free-running oscillator clock domain. It does not count oscillator edges directly. Instead, a 32-bit phase accumulator gains a programmable addend on every enabled oscillator cycle. Each time that accumulator carries out, the time value moves forward by a programmable period in nanoseconds. Software sets the addend to ceil(2^32 / R), where R is the oscillator frequency divided by the nominal tick frequency. This gives sub-cycle trimming of frequency drift. For example, a 50 MHz oscillator with a 40 MHz nominal rate gives R = 1.25 and an addend of 0xCCCCCCCD.

The carry pulses also drive a prescaler, which toggles a reference clock output pin. One instance serves every network port of the chip. A small register port sets the enable, addend, period and prescale value. The same port reads back the accumulator and the time value, and a high-word latch makes each 64-bit time read coherent.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset, every register reads zero: enable, addend, period, prescale, accumulator and time. The reference clock output is low.
- R2: While enabled, the accumulator adds the addend on every clock, modulo 2^32. A write to the addend takes effect on the next clock and leaves the accumulator unchanged.
- R3: Each carry out of the accumulator advances the time value by the period, and the time value wraps modulo 2^64.
- R4: While the enable (address 0, bit 0) is low, the accumulator, the time value and the reference clock output all hold.
- R5: The period field is 10 bits wide. A write keeps only bits 9:0 of the write data, and a read returns the field zero-extended.
- R6: A write to address 6 stages the upper 32 time bits. A write to address 5 loads the time with {staged, write data}. This load wins over a carry increment in the same cycle.
- R7: A read of address 5 returns the low time word and latches the high word from the same sample. A later read of address 6 returns that latched word.
- R8: The reference clock output toggles once for every P carry pulses, where P is the prescale value. P of 0 or 1 toggles it on every pulse.
- R9: The accumulator (address 4) is read-only, and a write to it has no effect.
- R10: Register addresses are: 0 enable, 1 addend, 2 period, 3 prescale (16 bits), 4 accumulator, 5 time low, 6 time high. Read data appears on the clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| ref_clk_out | output | 1 | Prescaled reference clock |

## Verification
The accumulator is exercised with several addends:
- A power-of-two addend gives evenly spaced carries, so a pulse-count error shows up at once.
- The fractional 0xCCCCCCCD addend leaves a non-zero residue, so a lost low bit shows up in the accumulator.
- The all-ones addend carries on almost every cycle, which separates load priority from increment.
- An addend change between runs shows whether the phase is kept or cleared.

Further runs load the time just below 2^64 to show the wrap, and a write of all ones to the period shows the truncation to 10 bits. A pair of reads split across a carry of the low word shows whether the high word comes from the sample taken at the low read. The prescaler is run with values 0, 1 and 3.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_ADDEND = 3'd1,
    A_PERIOD = 3'd2,
    A_PRESC  = 3'd3,
    A_ACC    = 3'd4,
    A_TLO    = 3'd5,
    A_THI    = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/ptc_phase_acc.sv
module ptc_phase_acc #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] addend,
  output logic [ACC_W-1:0] acc,
  output logic             ovf_pulse
);
  function automatic logic [ACC_W:0] phase_sum(input logic [ACC_W-1:0] a,
                                               input logic [ACC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [ACC_W:0] sum;
  assign sum       = phase_sum(acc, addend);
  assign ovf_pulse = en & sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n)  acc <= '0;
    else if (en) acc <= sum[ACC_W-1:0];
  end

  a_r2_acc_adds: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> acc == ACC_W'($past(acc) + $past(addend)));
  a_r4_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc));
endmodule

// File: rtl/ptc_time.sv
module ptc_time #(
  parameter int unsigned TIME_W   = 64,
  parameter int unsigned PERIOD_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic [PERIOD_W-1:0] period,
  input  logic                load,
  input  logic [TIME_W-1:0]   load_val,
  output logic [TIME_W-1:0]   time_q
);
  function automatic logic [TIME_W-1:0] advance(input logic [TIME_W-1:0] t,
                                                input logic [PERIOD_W-1:0] p);
    return t + TIME_W'(p);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     time_q <= '0;
    else if (load)  time_q <= load_val;
    else if (step)  time_q <= advance(time_q, period);
  end

  a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> time_q == $past(load_val));
  a_r3_step_adds: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> time_q == $past(time_q) + TIME_W'($past(period)));
  a_r4_time_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(time_q));
endmodule

// File: rtl/ptc_prescaler.sv
module ptc_prescaler #(
  parameter int unsigned PRESC_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pulse,
  input  logic [PRESC_W-1:0] presc,
  output logic               ref_clk
);
  logic [PRESC_W-1:0] count;
  logic               wrap;

  function automatic logic [PRESC_W-1:0] last_count(input logic [PRESC_W-1:0] p);
    return (p <= PRESC_W'(1)) ? '0 : p - PRESC_W'(1);
  endfunction

  assign wrap = (count >= last_count(presc));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      ref_clk <= 1'b0;
    end else if (pulse) begin
      if (wrap) begin
        count   <= '0;
        ref_clk <= ~ref_clk;
      end else begin
        count   <= count + PRESC_W'(1);
      end
    end
  end

  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse |=> $stable(ref_clk));
  a_r8_every_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && presc <= PRESC_W'(1)) |=> ref_clk != $past(ref_clk));
endmodule

// File: rtl/ptc_regs.sv
module ptc_regs
  import ptc_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PERIOD_W = 10,
  parameter int unsigned PRESC_W  = 16,
  localparam int unsigned TIME_W  = 2 * DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic [DATA_W-1:0]   acc,
  input  logic [TIME_W-1:0]   time_q,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                en,
  output logic [DATA_W-1:0]   addend,
  output logic [PERIOD_W-1:0] period,
  output logic [PRESC_W-1:0]  presc,
  output logic                load,
  output logic [TIME_W-1:0]   load_val
);
  reg_addr_e         sel;
  logic [DATA_W-1:0] hi_stage;
  logic [DATA_W-1:0] hi_latch;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_ctrl, wr_add, wr_per, wr_prs, wr_thi, rd_tlo;

  assign sel      = reg_addr_e'(reg_addr);
  assign wr_ctrl  = reg_wr && (sel == A_CTRL);
  assign wr_add   = reg_wr && (sel == A_ADDEND);
  assign wr_per   = reg_wr && (sel == A_PERIOD);
  assign wr_prs   = reg_wr && (sel == A_PRESC);
  assign wr_thi   = reg_wr && (sel == A_THI);
  assign load     = reg_wr && (sel == A_TLO);
  assign rd_tlo   = reg_rd && (sel == A_TLO);
  assign load_val = {hi_stage, reg_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en       <= 1'b0;
      addend   <= '0;
      period   <= '0;
      presc    <= '0;
      hi_stage <= '0;
    end else begin
      if (wr_ctrl) en       <= reg_wdata[0];
      if (wr_add)  addend   <= reg_wdata;
      if (wr_per)  period   <= reg_wdata[PERIOD_W-1:0];
      if (wr_prs)  presc    <= reg_wdata[PRESC_W-1:0];
      if (wr_thi)  hi_stage <= reg_wdata;
    end
  end

  always_comb begin
    case (sel)
      A_CTRL:   rd_mux = DATA_W'(en);
      A_ADDEND: rd_mux = addend;
      A_PERIOD: rd_mux = DATA_W'(period);
      A_PRESC:  rd_mux = DATA_W'(presc);
      A_ACC:    rd_mux = acc;
      A_TLO:    rd_mux = time_q[DATA_W-1:0];
      A_THI:    rd_mux = hi_latch;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      hi_latch  <= '0;
    end else begin
      if (reg_rd) reg_rdata <= rd_mux;
      if (rd_tlo) hi_latch  <= time_q[TIME_W-1:DATA_W];
    end
  end

  a_r7_hi_latch: assert property (@(posedge clk) disable iff (!rst_n)
    rd_tlo |=> hi_latch == $past(time_q[TIME_W-1:DATA_W]));
  a_r9_acc_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && sel == A_ACC) |=> reg_rdata == $past(acc));
  a_r2_addend_next: assert property (@(posedge clk) disable iff (!rst_n)
    wr_add |=> addend == $past(reg_wdata));
  a_r5_period_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && sel == A_PERIOD) |=> reg_rdata[DATA_W-1:PERIOD_W] == '0);
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptc_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PERIOD_W = 10,
  parameter int unsigned PRESC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              ref_clk_out
);
  localparam int unsigned TIME_W = 2 * DATA_W;

  logic                en;
  logic [DATA_W-1:0]   addend;
  logic [DATA_W-1:0]   acc;
  logic                ovf_pulse;
  logic [PERIOD_W-1:0] period;
  logic [PRESC_W-1:0]  presc;
  logic                load;
  logic [TIME_W-1:0]   load_val;
  logic [TIME_W-1:0]   time_q;

  ptc_regs #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W), .PRESC_W(PRESC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .acc(acc), .time_q(time_q),
    .reg_rdata(reg_rdata), .en(en), .addend(addend), .period(period),
    .presc(presc), .load(load), .load_val(load_val)
  );

  ptc_phase_acc #(.ACC_W(DATA_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(en), .addend(addend),
    .acc(acc), .ovf_pulse(ovf_pulse)
  );

  ptc_time #(.TIME_W(TIME_W), .PERIOD_W(PERIOD_W)) u_time (
    .clk(clk), .rst_n(rst_n), .step(ovf_pulse), .period(period),
    .load(load), .load_val(load_val), .time_q(time_q)
  );

  ptc_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .pulse(ovf_pulse), .presc(presc),
    .ref_clk(ref_clk_out)
  );

  a_r4_no_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !ovf_pulse);
endmodule

// File: tb/ptp_time_counter_tb.sv
module ptp_time_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] CTRL = 0, ADD = 1, PER = 2, PRS = 3, ACC = 4, TLO = 5, THI = 6;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        ref_clk_out;

  int checks = 0, errors = 0;
  int tog_cnt = 0;
  logic prev_ref = 0;

  // expected model state
  longint unsigned m_acc, m_time, m_pulses;
  longint unsigned m_add, m_per;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptp_time_counter u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ref_clk_out(ref_clk_out)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      tog_cnt = 0;
      prev_ref = 0;
    end else begin
      if (ref_clk_out !== prev_ref) tog_cnt = tog_cnt + 1;
      prev_ref = ref_clk_out;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; reg_wr = 0; reg_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_acc = 0; m_time = 0; m_pulses = 0; m_add = 0; m_per = 0;
  endtask

  // called at a negedge; returns at the following negedge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  // enable, M extra cycles, disable: M+1 accumulating edges
  task automatic run_enabled(input int m);
    wr(CTRL, 1);
    repeat (m) @(negedge clk);
    wr(CTRL, 0);
    begin
      longint unsigned tot = m_acc + longint'(m + 1) * m_add;
      longint unsigned ov  = tot >> 32;
      m_acc    = tot & 64'hFFFF_FFFF;
      m_time   = m_time + ov * m_per;
      m_pulses = m_pulses + ov;
    end
  endtask

  task automatic check_state(input string req);
    logic [31:0] lo, hi, ac;
    rd(ACC, ac);
    check(req, "accumulator", 64'(ac), m_acc);
    rd(TLO, lo);
    rd(THI, hi);
    check(req, "time", {hi, lo}, m_time);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    check("R1", "ref_clk_out", 64'(ref_clk_out), 0);
    foreach (d[i]) begin end
    for (int a = 0; a < 7; a++) begin
      rd(a[2:0], d);
      check("R1", $sformatf("reg %0d", a), 64'(d), 0);
    end
    wr(PRS, 32'h0001_1234);
    rd(PRS, d);
    check("R10", "prescale readback 16 bits", 64'(d), 64'h1234);
    wr(CTRL, 32'h3);
    rd(CTRL, d);
    check("R10", "enable readback", 64'(d), 1);
    wr(CTRL, 0);
  endtask

  task automatic t_basic();
    do_reset();
    m_add = 32'h4000_0000; m_per = 10;
    wr(ADD, 32'h4000_0000);
    wr(PER, 10);
    run_enabled(15);
    check_state("R3");
    check("R8", "toggles with prescale 0", 64'(tog_cnt), m_pulses);
  endtask

  task automatic t_frac_hold();
    int t0;
    do_reset();
    m_add = 32'hCCCC_CCCD; m_per = 8;
    wr(ADD, 32'hCCCC_CCCD);
    wr(PER, 8);
    run_enabled(99);
    check_state("R2");
    t0 = tog_cnt;
    repeat (20) @(negedge clk);
    check_state("R4");
    check("R4", "no toggles while disabled", 64'(tog_cnt), 64'(t0));
  endtask

  task automatic t_addend_live();
    logic [31:0] d;
    do_reset();
    m_add = 32'h3000_0000; m_per = 5;
    wr(ADD, 32'h3000_0000);
    wr(PER, 5);
    run_enabled(9);
    m_add = 32'h5000_0000;
    wr(ADD, 32'h5000_0000);
    rd(ACC, d);
    check("R2", "addend write keeps accumulator", 64'(d), m_acc);
    run_enabled(3);
    check_state("R2");
  endtask

  task automatic t_period_max();
    logic [31:0] d;
    do_reset();
    wr(PER, 32'hFFFF_FFFF);
    rd(PER, d);
    check("R5", "period truncated", 64'(d), 64'h3FF);
    m_add = 32'h8000_0000; m_per = 1023;
    wr(ADD, 32'h8000_0000);
    run_enabled(5);
    check_state("R5");
  endtask

  task automatic t_wrap();
    do_reset();
    m_add = 32'h8000_0000; m_per = 10;
    wr(ADD, 32'h8000_0000);
    wr(PER, 10);
    wr(THI, 32'hFFFF_FFFF);
    wr(TLO, 32'hFFFF_FFFB);
    m_time = 64'hFFFF_FFFF_FFFF_FFFB;
    run_enabled(5);
    check_state("R3");
  endtask

  task automatic t_load_priority();
    logic [31:0] lo, hi;
    do_reset();
    wr(ADD, 32'hFFFF_FFFF);
    wr(PER, 7);
    wr(CTRL, 1);
    repeat (4) @(negedge clk);
    wr(THI, 32'h12);
    wr(TLO, 32'h34);      // carry pulse present on this edge
    wr(CTRL, 0);          // one more carry before the enable drops
    rd(TLO, lo);
    rd(THI, hi);
    check("R6", "load beats increment", {hi, lo}, 64'h0000_0012_0000_003B);
  endtask

  task automatic t_atomic();
    logic [31:0] d;
    do_reset();
    m_add = 32'h8000_0000; m_per = 16;
    wr(ADD, 32'h8000_0000);
    wr(PER, 16);
    wr(THI, 0);
    wr(TLO, 32'hFFFF_FFF0);
    m_time = 64'h0000_0000_FFFF_FFF0;
    rd(TLO, d);
    check("R7", "low word", 64'(d), 64'hFFFF_FFF0);
    run_enabled(3);
    rd(THI, d);
    check("R7", "high word from earlier sample", 64'(d), 0);
    rd(TLO, d);
    check("R7", "new low word", 64'(d), m_time[31:0]);
    rd(THI, d);
    check("R7", "new high word", 64'(d), m_time[63:32]);
  endtask

  task automatic t_presc(input int p, input int m);
    int lim;
    do_reset();
    lim = (p <= 1) ? 1 : p;
    m_add = 32'h8000_0000; m_per = 1;
    wr(PRS, p);
    wr(ADD, 32'h8000_0000);
    wr(PER, 1);
    run_enabled(m);
    @(negedge clk);
    check("R8", $sformatf("toggles presc %0d", p), 64'(tog_cnt), m_pulses / lim);
    check("R8", $sformatf("level presc %0d", p), 64'(ref_clk_out), (m_pulses / lim) & 1);
  endtask

  task automatic t_acc_ro();
    logic [31:0] d;
    do_reset();
    m_add = 32'h1000_0000;
    wr(ADD, 32'h1000_0000);
    run_enabled(2);
    wr(ACC, 32'hDEAD_BEEF);
    rd(ACC, d);
    check("R9", "accumulator write ignored", 64'(d), 64'h3000_0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_frac_hold();
    t_addend_live();
    t_period_max();
    t_wrap();
    t_load_priority();
    t_atomic();
    t_presc(3, 23);
    t_presc(1, 9);
    t_presc(0, 7);
    t_acc_ro();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule